// File: doc/BRIEF.md
# USB Charger Type Detection Sequencer

This block classifies the power source attached to a USB receptacle once the bus supply is reported valid. It is a finite-state machine fed by digital flags: a bus-valid flag, a data-contact flag and comparator results for the D+ and D− lines. The flags report a pull-down on the data lines, a short between D+ and D−, hits in two proprietary voltage windows, and pull-ups to the bus supply. The analog comparators, current sources and the data switch sit outside the block.

The block first waits for data contact, with a timeout. When contact arrives in time, it runs a debounce interval and then a two-step compliant check. The first step separates a standard downstream port from the charging types. The second step tells a dedicated charging port from a charging downstream port. When contact never arrives, the block falls back to line-voltage checks for proprietary, PS/2-style and non-compliant sources. Intervals are counted in millisecond ticks produced by a parameterised prescaler, so a test build can shrink every timeout. The classification code and a one-cycle done strobe change only when detection ends.

Top module: `usb_chg_classifier`

## Requirements
- R1: Out of reset, and while `vbus_ok` is low, `chg_type` is NONE (code 0) and `det_done` is low. No detection runs.
- R2: If `dcd_contact` is high during contact detection, a debounce of DEB_MS ticks runs before classification. `det_done` pulses no earlier than DEB_MS×CLKS_PER_MS cycles and no later than 8 cycles after that, counted from `vbus_ok` rising.
- R3: In the compliant path, `ln_pulldn` high gives SDP (code 1).
- R4: In the compliant path with `ln_pulldn` low, `ln_short` high gives DCP (code 3); otherwise the result is CDP (code 2).
- R5: If contact is not seen within DCD_MS ticks, detection ends through the fallback path. `det_done` pulses no earlier than DCD_MS×CLKS_PER_MS cycles and no later than 8 cycles after that, counted from `vbus_ok` rising.
- R6: Fallback checks the flags in priority order: `win_a` gives PROP_A (code 4), then `win_b` gives PROP_B (code 5), then `ln_pullup` gives PS2 (code 6). With none of them set the result is NONCOMPLIANT (code 7). When both windows hit, PROP_A wins.
- R7: `chg_type` changes only in the cycle in which `det_done` is high, or when it returns to NONE. `det_done` is never high for two consecutive cycles.
- R8: When `vbus_ok` falls in any state, the next clock sets `chg_type` to NONE and abandons detection. A later rise of `vbus_ok` restarts detection with full timing.
- R9: If contact arrives only after the contact-detect timeout (slow insertion), it has no effect: the result is the fallback classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vbus_ok | input | 1 | Bus supply above its valid threshold |
| dcd_contact | input | 1 | Data lines have made contact |
| ln_pulldn | input | 1 | Pull-down seen on the data lines (primary check) |
| ln_short | input | 1 | D+ shorted to D− (secondary check) |
| win_a | input | 1 | Both lines inside the narrower proprietary window |
| win_b | input | 1 | Both lines inside the wider proprietary window |
| ln_pullup | input | 1 | Both lines pulled up to the bus supply |
| chg_type | output | 4 | Classification code, per R1, R3, R4 and R6 |
| det_done | output | 1 | One-cycle strobe at the end of detection |

## Verification
The state register is hidden, but a wrong state still shows at the ports. A state entered too early or too late moves the `det_done` pulse outside its latency window. This is visible one debounce or one timeout interval after `vbus_ok` rises. A wrong branch at the primary, secondary or fallback step shows as a wrong `chg_type` in the same cycle as the strobe. A state that fails to return to idle shows one cycle after `vbus_ok` falls, as a non-zero code or as a strobe with no restart.

// File: rtl/usbchg_pkg.sv
package usbchg_pkg;
   localparam int TYPE_W = 4;

   typedef enum logic [TYPE_W-1:0] {
      CT_NONE    = 4'd0,
      CT_SDP     = 4'd1,
      CT_CDP     = 4'd2,
      CT_DCP     = 4'd3,
      CT_PROP_A  = 4'd4,
      CT_PROP_B  = 4'd5,
      CT_PS2     = 4'd6,
      CT_NONSTD  = 4'd7
   } chg_type_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DCD, ST_DEB, ST_PRI, ST_SEC, ST_FB, ST_DONE
   } det_state_e;
endpackage

// File: rtl/usbchg_tick_gen.sv
module usbchg_tick_gen #(
   parameter int CLKS_PER_MS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (CLKS_PER_MS == 1) begin : g_pass
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= ~clr;
         end
         assign tick = tick_q & ~clr;
      end else begin : g_div
         localparam int PW = $clog2(CLKS_PER_MS);
         localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             pre_q <= '0;
            else if (clr)           pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                    pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/usbchg_ms_timer.sv
module usbchg_ms_timer #(
   parameter int MS_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            tick,
   input  logic [MS_W-1:0] limit,
   output logic            expired
);
   logic [MS_W-1:0] ms_q;

   assign expired = (ms_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ms_q <= '0;
      else if (clr)            ms_q <= '0;
      else if (tick && !expired) ms_q <= ms_q + 1'b1;
   end
endmodule

// File: rtl/usbchg_classify.sv
module usbchg_classify
   import usbchg_pkg::*;
(
   input  logic      ln_short,
   input  logic      win_a,
   input  logic      win_b,
   input  logic      ln_pullup,
   output chg_type_e sec_type,
   output chg_type_e fb_type
);
   assign sec_type = ln_short ? CT_DCP : CT_CDP;

   always_comb begin
      if (win_a)          fb_type = CT_PROP_A;
      else if (win_b)     fb_type = CT_PROP_B;
      else if (ln_pullup) fb_type = CT_PS2;
      else                fb_type = CT_NONSTD;
   end
endmodule

// File: rtl/usb_chg_classifier.sv
module usb_chg_classifier
   import usbchg_pkg::*;
#(
   parameter int CLKS_PER_MS = 50000,
   parameter int DCD_MS      = 600,
   parameter int DEB_MS      = 130
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vbus_ok,
   input  logic              dcd_contact,
   input  logic              ln_pulldn,
   input  logic              ln_short,
   input  logic              win_a,
   input  logic              win_b,
   input  logic              ln_pullup,
   output logic [TYPE_W-1:0] chg_type,
   output logic              det_done
);
   localparam int MS_W = $clog2(DCD_MS + 1);
   localparam logic [MS_W-1:0] DCD_LIM = MS_W'(DCD_MS);
   localparam logic [MS_W-1:0] DEB_LIM = MS_W'(DEB_MS);

   generate
      if (CLKS_PER_MS < 1 || DEB_MS < 1 || DCD_MS <= DEB_MS) begin : g_bad_cfg
         $error("usb_chg_classifier: need CLKS_PER_MS>=1, DEB_MS>=1, DCD_MS>DEB_MS");
      end
   endgenerate

   det_state_e st_q, st_d;
   chg_type_e  ty_q, ty_d;
   logic       done_q, done_d;
   logic       tmr_clr, tick, expired;
   logic [MS_W-1:0] limit;
   chg_type_e  sec_type, fb_type;

   assign tmr_clr = (st_q != st_d) || (st_q == ST_IDLE);
   assign limit   = (st_q == ST_DCD) ? DCD_LIM : DEB_LIM;

   usbchg_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick)
   );

   usbchg_ms_timer #(.MS_W(MS_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick),
      .limit(limit), .expired(expired)
   );

   usbchg_classify u_cls (
      .ln_short(ln_short), .win_a(win_a), .win_b(win_b),
      .ln_pullup(ln_pullup), .sec_type(sec_type), .fb_type(fb_type)
   );

   always_comb begin
      st_d = st_q;
      ty_d = ty_q;
      unique case (st_q)
         ST_IDLE: st_d = ST_DCD;
         ST_DCD: begin
            if (dcd_contact)  st_d = ST_DEB;
            else if (expired) st_d = ST_FB;
         end
         ST_DEB:  if (expired) st_d = ST_PRI;
         ST_PRI: begin
            if (ln_pulldn) begin
               st_d = ST_DONE;
               ty_d = CT_SDP;
            end else begin
               st_d = ST_SEC;
            end
         end
         ST_SEC: begin
            st_d = ST_DONE;
            ty_d = sec_type;
         end
         ST_FB: begin
            st_d = ST_DONE;
            ty_d = fb_type;
         end
         ST_DONE: st_d = ST_DONE;
         default: st_d = ST_IDLE;
      endcase
      if (!vbus_ok) begin
         st_d = ST_IDLE;
         ty_d = CT_NONE;
      end
   end

   assign done_d = (st_d == ST_DONE) && (st_q != ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ty_q   <= CT_NONE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         ty_q   <= ty_d;
         done_q <= done_d;
      end
   end

   assign chg_type = ty_q;
   assign det_done = done_q;
endmodule

// File: rtl/usb_chg_classifier_chk.sv
module usb_chg_classifier_chk
   import usbchg_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              vbus_ok,
   input logic              ln_pulldn,
   input logic              ln_short,
   input logic              win_a,
   input logic [TYPE_W-1:0] chg_type,
   input logic              det_done
);
   a_r8_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !vbus_ok |=> (chg_type == TYPE_W'(CT_NONE)));

   a_r1_no_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !vbus_ok |=> !det_done);

   a_r7_type_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chg_type) |-> (det_done || chg_type == TYPE_W'(CT_NONE)));

   a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      det_done |=> !det_done);

   a_r3_sdp_pulldn: assert property (@(posedge clk) disable iff (!rst_n)
      (det_done && chg_type == TYPE_W'(CT_SDP)) |-> $past(ln_pulldn));

   a_r4_dcp_short: assert property (@(posedge clk) disable iff (!rst_n)
      (det_done && chg_type == TYPE_W'(CT_DCP)) |-> $past(ln_short));

   a_r6_prop_a_first: assert property (@(posedge clk) disable iff (!rst_n)
      (det_done && chg_type == TYPE_W'(CT_PROP_B)) |-> !$past(win_a));
endmodule

bind usb_chg_classifier usb_chg_classifier_chk u_chk (
   .clk(clk), .rst_n(rst_n), .vbus_ok(vbus_ok), .ln_pulldn(ln_pulldn),
   .ln_short(ln_short), .win_a(win_a), .chg_type(chg_type), .det_done(det_done)
);

// File: tb/usb_chg_classifier_bench.sv
module usb_chg_classifier_bench;
   localparam int CPM = 4;
   localparam int DCD = 6;
   localparam int DEB = 3;
   localparam int SLACK = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vbus_ok = 1'b0, dcd_contact = 1'b0, ln_pulldn = 1'b0, ln_short = 1'b0;
   logic win_a = 1'b0, win_b = 1'b0, ln_pullup = 1'b0;
   logic [3:0] chg_type;
   logic det_done;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   usb_chg_classifier #(.CLKS_PER_MS(CPM), .DCD_MS(DCD), .DEB_MS(DEB)) u_usb_chg_classifier (
      .clk(clk), .rst_n(rst_n), .vbus_ok(vbus_ok), .dcd_contact(dcd_contact),
      .ln_pulldn(ln_pulldn), .ln_short(ln_short), .win_a(win_a), .win_b(win_b),
      .ln_pullup(ln_pullup), .chg_type(chg_type), .det_done(det_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Raise vbus, wait for the strobe; return latency, type and whether type moved early.
   task automatic run_det(output int lat, output int ty, output bit early_chg, input int late_contact);
      early_chg = 1'b0;
      lat = 0;
      @(negedge clk);
      vbus_ok = 1'b1;
      for (int i = 0; i < 200; i++) begin
         @(posedge clk); #1;
         lat++;
         if (late_contact > 0 && lat == late_contact) dcd_contact = 1'b1;
         if (det_done) break;
         if (chg_type != 4'd0) early_chg = 1'b1;
      end
      ty = chg_type;
   endtask

   task automatic drop_vbus();
      @(negedge clk);
      vbus_ok = 1'b0;
      dcd_contact = 1'b0;
      @(posedge clk); #1;
      check(chg_type == 4'd0 && !det_done, "R8", chg_type, 0);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      int lat, ty, exp;
      bit early;
      repeat (3) @(posedge clk);
      #1;
      check(chg_type == 4'd0, "R1 reset type", chg_type, 0);
      check(det_done == 1'b0, "R1 reset done", det_done, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (10) @(posedge clk);
      #1;
      check(chg_type == 4'd0 && !det_done, "R1 idle without vbus", chg_type, 0);

      // Compliant path sweep (R2, R3, R4)
      for (int c = 0; c < 4; c++) begin
         ln_pulldn = c[0];
         ln_short  = c[1];
         dcd_contact = 1'b1;
         run_det(lat, ty, early, 0);
         exp = ln_pulldn ? 1 : (ln_short ? 3 : 2);
         check(ty == exp, ln_pulldn ? "R3 sdp" : "R4 secondary", ty, exp);
         check(lat >= DEB*CPM && lat <= DEB*CPM + SLACK, "R2 debounce latency", lat, DEB*CPM);
         check(!early, "R7 type held until end", ty, exp);
         drop_vbus();
      end
      ln_pulldn = 1'b0; ln_short = 1'b0;

      // Fallback sweep (R5, R6)
      for (int c = 0; c < 8; c++) begin
         win_a = c[0]; win_b = c[1]; ln_pullup = c[2];
         dcd_contact = 1'b0;
         run_det(lat, ty, early, 0);
         exp = win_a ? 4 : (win_b ? 5 : (ln_pullup ? 6 : 7));
         check(ty == exp, "R6 fallback priority", ty, exp);
         check(lat >= DCD*CPM && lat <= DCD*CPM + SLACK, "R5 timeout latency", lat, DCD*CPM);
         check(!early, "R7 type held until end", ty, exp);
         @(posedge clk); #1;
         check(!det_done && chg_type == exp[3:0], "R7 single strobe", det_done, 0);
         drop_vbus();
      end
      win_a = 1'b0; win_b = 1'b0; ln_pullup = 1'b0;

      // Slow insertion: contact after timeout is ignored (R9)
      ln_pulldn = 1'b1;
      run_det(lat, ty, early, DCD*CPM + 2);
      check(ty == 7, "R9 late contact ignored", ty, 7);
      check(lat >= DCD*CPM, "R9 fallback timing", lat, DCD*CPM);
      drop_vbus();
      ln_pulldn = 1'b0;

      // Vbus drop mid-detection, then restart (R8)
      dcd_contact = 1'b1;
      ln_short = 1'b1;
      @(negedge clk); vbus_ok = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk); vbus_ok = 1'b0;
      begin
         bit seen = 1'b0;
         for (int i = 0; i < DEB*CPM + SLACK; i++) begin
            @(posedge clk); #1;
            if (det_done || chg_type != 4'd0) seen = 1'b1;
         end
         check(!seen, "R8 abandoned detection", seen, 0);
      end
      run_det(lat, ty, early, 0);
      check(ty == 3, "R8 restart result", ty, 3);
      check(lat >= DEB*CPM, "R8 restart full timing", lat, DEB*CPM);
      drop_vbus();

      summary();
   end
endmodule